// File: doc/BRIEF.md
# Overcurrent Hiccup and Thermal Fault Gate

This block decides, once per switching cycle, whether a step-down power stage is allowed to switch. A one-clock tick marks each switching cycle. On every tick the block samples a current-limit flag and a temperature code. When the limit is hit on several ticks in a row, it enters a hiccup blackout of fixed length. It also holds a thermal shutdown latch with hysteresis. Both faults clear by themselves, with no outside action.

Enable and under-voltage lockout act at once, without waiting for a tick. Either one blocks switching and discards any pending hiccup state. The thermal latch tracks the physical temperature, so enable and lockout leave it alone. PWM generation, current sensing and the analog comparators sit outside this block.

Top module: `fault_gate`

## Requirements
- R1: `sw_en_o` is high exactly when `en_i` is high, `uvlo_i` is low, `hiccup_o` is low and `thermal_o` is low. A change of `en_i` or `uvlo_i` reaches `sw_en_o` in the same cycle.
- R2: Suppose `ilim_i` is high on 4 consecutive ticks while no blackout is running. Then `hiccup_o` is high and `sw_en_o` is low from the clock edge that samples the fourth tick.
- R3: Any tick with `ilim_i` low restarts the consecutive count from zero. Clock edges without `tick_i` leave the count, the blackout and the thermal latch unchanged.
- R4: Once the hiccup starts, it lasts exactly 7 further ticks. `hiccup_o` falls at the edge that samples the seventh of them.
- R5: `ilim_i` is ignored during the blackout. After the blackout, 4 new consecutive limit ticks are needed to trip again.
- R6: The temperature input is a 9-bit two's-complement value in °C. `thermal_o` sets on a tick whose temperature is 140 or more.
- R7: `thermal_o` clears on a tick whose temperature is 125 or less. Between 126 and 139 it keeps its previous value.
- R8: While `en_i` is low or `uvlo_i` is high, the consecutive count and the blackout are cleared at the next clock edge. `thermal_o` is not affected.
- R9: During and right after reset, `hiccup_o` and `thermal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse per switching cycle |
| ilim_i | input | 1 | Current limit reached in this switching cycle |
| temp_i | input | 9 | Junction temperature, signed °C |
| uvlo_i | input | 1 | Input supply below lockout threshold |
| en_i | input | 1 | Converter enable |
| sw_en_o | output | 1 | Power stage may switch |
| hiccup_o | output | 1 | Overcurrent blackout active |
| thermal_o | output | 1 | Thermal shutdown active |

## Verification
The overcurrent trip and the thermal set can fall on the same tick. They can also overlap, with the blackout ending while the thermal latch stays on. The bench provokes the first case by raising the temperature to 140 on the tick that carries the fourth consecutive limit hit. It checks that both flags rise at the same edge. It then lets the blackout run out and checks that switching stays off until a tick at 125 or below. A second overlap is an enable drop in the middle of a blackout. After it, both the blackout and the count must be gone, and the thermal latch must be kept.

// File: rtl/fault_gate_pkg.sv
package fault_gate_pkg;
  localparam int unsigned TEMP_W      = 9;
  localparam int unsigned TRIP_TICKS  = 4;
  localparam int unsigned BLANK_TICKS = 7;
  localparam int          HOT_SET_C   = 140;
  localparam int          HOT_CLR_C   = 125;

  typedef logic signed [TEMP_W-1:0] temp_t;
endpackage

// File: rtl/fg_ocp_hiccup.sv
module fg_ocp_hiccup #(
  parameter int unsigned TRIP  = fault_gate_pkg::TRIP_TICKS,
  parameter int unsigned BLANK = fault_gate_pkg::BLANK_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ilim_i,
  input  logic hold_i,
  output logic hiccup_o
);
  localparam int unsigned RUN_W = (TRIP  > 2) ? $clog2(TRIP)  : 1;
  localparam int unsigned BLK_W = (BLANK > 2) ? $clog2(BLANK) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(TRIP - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLANK - 1);

  logic [RUN_W-1:0] run_q;
  logic [BLK_W-1:0] blk_q;
  logic             hic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      blk_q <= '0;
      hic_q <= 1'b0;
    end else if (hold_i) begin
      run_q <= '0;
      blk_q <= '0;
      hic_q <= 1'b0;
    end else if (tick_i) begin
      if (hic_q) begin
        run_q <= '0;
        if (blk_q == '0) hic_q <= 1'b0;
        else             blk_q <= blk_q - 1'b1;
      end else if (ilim_i) begin
        if (run_q == RUN_LAST) begin
          run_q <= '0;
          blk_q <= BLK_LAST;
          hic_q <= 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign hiccup_o = hic_q;

  // R2
  hic_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hic_q) |-> $past(tick_i && ilim_i && !hold_i));
  // R8
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> (!hic_q && run_q == '0));
  // R3
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!tick_i && !hold_i) |-> ($stable(run_q) && $stable(blk_q) && $stable(hic_q)));
  // R4
  blk_only_in_hic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_q != '0) |-> hic_q);
  // R5
  run_idle_in_hic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hic_q |-> (run_q == '0));
endmodule

// File: rtl/fg_thermal.sv
module fg_thermal
  import fault_gate_pkg::*;
#(
  parameter int SET_C = HOT_SET_C,
  parameter int CLR_C = HOT_CLR_C
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  temp_t temp_i,
  output logic  hot_o
);
  localparam temp_t SET_T = temp_t'(SET_C);
  localparam temp_t CLR_T = temp_t'(CLR_C);

  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hot_q <= 1'b0;
    else if (tick_i && temp_i >= SET_T)   hot_q <= 1'b1;
    else if (tick_i && temp_i <= CLR_T)   hot_q <= 1'b0;
  end

  assign hot_o = hot_q;

  // R6
  hot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hot_q) |-> $past(tick_i && temp_i >= SET_T));
  // R7
  hot_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hot_q) |-> $past(tick_i && temp_i <= CLR_T));
endmodule

// File: rtl/fault_gate.sv
module fault_gate
  import fault_gate_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     ilim_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     uvlo_i,
  input  logic                     en_i,
  output logic                     sw_en_o,
  output logic                     hiccup_o,
  output logic                     thermal_o
);
  logic hold;
  logic hic;
  logic hot;

  assign hold = !en_i || uvlo_i;

  fg_ocp_hiccup #(.TRIP(TRIP_TICKS), .BLANK(BLANK_TICKS)) u_ocp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ilim_i   (ilim_i),
    .hold_i   (hold),
    .hiccup_o (hic)
  );

  fg_thermal #(.SET_C(HOT_SET_C), .CLR_C(HOT_CLR_C)) u_thm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .temp_i (temp_i),
    .hot_o  (hot)
  );

  assign sw_en_o   = !hold && !hic && !hot;
  assign hiccup_o  = hic;
  assign thermal_o = hot;

  // R1
  no_switch_in_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiccup_o || thermal_o || uvlo_i) |-> !sw_en_o);
endmodule

// File: tb/sim_fault_gate.sv
`timescale 1ns/1ps
module sim_fault_gate;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ilim = 1'b0, uvlo = 1'b0, en = 1'b0;
  logic signed [8:0] temp = 9'sd25;
  logic sw_en, hiccup, thermal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_run = 0, m_blk = 0;
  bit m_hic = 1'b0, m_th = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  fault_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ilim_i(ilim), .temp_i(temp),
    .uvlo_i(uvlo), .en_i(en), .sw_en_o(sw_en), .hiccup_o(hiccup), .thermal_o(thermal)
  );

  task automatic check(input string req);
    bit hold;
    bit e_sw;
    hold = !en || uvlo;
    e_sw = !hold && !m_hic && !m_th;
    checks++;
    if (sw_en !== e_sw || hiccup !== m_hic || thermal !== m_th) begin
      errors++;
      $display("FAIL %s t=%0t sw/hic/th actual=%b%b%b expected=%b%b%b",
               req, $time, sw_en, hiccup, thermal, e_sw, m_hic, m_th);
    end
  endtask

  task automatic model_edge();
    if (!en || uvlo) begin
      m_run = 0; m_blk = 0; m_hic = 1'b0;
    end else if (tick) begin
      if (m_hic) begin
        m_run = 0;
        if (m_blk == 0) m_hic = 1'b0; else m_blk--;
      end else if (ilim) begin
        if (m_run == 3) begin m_run = 0; m_blk = 6; m_hic = 1'b1; end
        else m_run++;
      end else m_run = 0;
    end
    if (tick) begin
      if (temp >= 140) m_th = 1'b1;
      else if (temp <= 125) m_th = 1'b0;
    end
  endtask

  // drive at negedge, check combinational response, take one clock
  task automatic cyc(input bit t, input bit il, input int tc, input bit uv,
                     input bit e, input string req);
    tick = t; ilim = il; temp = 9'(tc); uvlo = uv; en = e;
    #1;
    check(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset");

    // R1: enable and lockout gating
    cyc(1, 0, 25, 0, 1, "R1 enabled");
    cyc(1, 0, 25, 1, 1, "R1 uvlo");
    cyc(0, 0, 25, 0, 0, "R1 disabled");
    cyc(1, 0, 25, 0, 1, "R1 re-enable");

    // R3: three hits, a miss, then three more: no trip
    for (int i = 0; i < 3; i++) cyc(1, 1, 25, 0, 1, "R3 run");
    cyc(1, 0, 25, 0, 1, "R3 miss");
    for (int i = 0; i < 3; i++) cyc(1, 1, 25, 0, 1, "R3 run2");
    cyc(1, 0, 25, 0, 1, "R3 miss2");

    // R2 with sparse ticks: idle clocks between hits (R3)
    for (int i = 0; i < 4; i++) begin
      cyc(1, 1, 25, 0, 1, "R2 hit");
      cyc(0, 0, 25, 0, 1, "R3 no tick");
      cyc(0, 1, 25, 0, 1, "R3 no tick ilim");
    end
    check("R2 tripped");

    // R4/R5: blackout with ilim held high, idle clocks inside
    for (int i = 0; i < 7; i++) begin
      cyc(1, 1, 25, 0, 1, "R4 blank");
      cyc(0, 1, 25, 0, 1, "R4 idle");
    end
    check("R4 blank over");
    for (int i = 0; i < 3; i++) cyc(1, 1, 25, 0, 1, "R5 recount");
    check("R5 no early trip");
    cyc(1, 1, 25, 0, 1, "R5 fourth");
    check("R5 retrip");

    // R8: enable drop mid-blackout clears it
    cyc(1, 0, 25, 0, 1, "R8 blank");
    cyc(0, 0, 25, 0, 0, "R8 disable");
    cyc(0, 0, 25, 0, 1, "R8 cleared");
    for (int i = 0; i < 3; i++) cyc(1, 1, 25, 0, 1, "R8 fresh count");
    cyc(0, 0, 25, 1, 1, "R8 uvlo clears count");
    for (int i = 0; i < 3; i++) cyc(1, 1, 25, 0, 1, "R8 count after uvlo");
    cyc(1, 0, 25, 0, 1, "R8 no trip");

    // R6/R7: thermal hysteresis
    cyc(1, 0, 139, 0, 1, "R6 below");
    cyc(0, 0, 150, 0, 1, "R3 thermal needs tick");
    cyc(1, 0, 140, 0, 1, "R6 set");
    cyc(1, 0, 139, 0, 1, "R7 hold 139");
    cyc(1, 0, 126, 0, 1, "R7 hold 126");
    cyc(0, 0, 25, 0, 0, "R8 thermal kept on disable");
    cyc(1, 0, 126, 0, 1, "R7 still 126");
    cyc(0, 0, 100, 0, 1, "R3 clear needs tick");
    cyc(1, 0, 125, 0, 1, "R7 clear");
    cyc(1, 0, 200, 0, 1, "R6 set 200");
    cyc(1, 0, -40, 0, 1, "R7 clear negative");
    cyc(1, 0, -40, 0, 1, "R7 off");

    // overlap: trip and thermal set on the same tick
    for (int i = 0; i < 3; i++) cyc(1, 1, 120, 0, 1, "R2 overlap run");
    cyc(1, 1, 140, 0, 1, "R6 overlap trip");
    check("R2 R6 both");
    for (int i = 0; i < 8; i++) cyc(1, 0, 130, 0, 1, "R4 blank under thermal");
    cyc(1, 0, 124, 0, 1, "R7 overlap release");
    cyc(1, 0, 124, 0, 1, "R1 running");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule